// File: doc/BRIEF.md
# Windowed Pulse Integral Extractor

This block watches one digitised channel and, on a trigger, reduces a window of that channel's samples to a few labelled figures. The window is placed by a signed start offset counted in samples from the trigger sample, which is time zero. Its length is a separate input. Over the window the block adds up every sample minus the baseline that was present at the trigger. It also averages the four samples just before the window and the four samples just after it. The window may start before the trigger, because every incoming sample is kept in a short history ring. A window that reaches past the present time waits until the samples it needs have arrived.

Each trigger yields five 32-bit result words on a valid/ready stream, always in the same order. Each word carries an 8-bit label in its top byte and a 24-bit value below it. The label is a feature code plus sixteen times the channel number. A trigger that arrives while the previous window is still being reduced or drained is dropped, and a sticky overrun flag records that it happened.

Top module: `pulse_window_extractor`

## Requirements
- R1: After reset, `out_valid_o` and `ovr_o` are low.
- R2: A trigger accepted while idle produces exactly five words, in this order: window start, baseline, pre-window mean, integral, post-window mean. Their feature codes are 0x30, 0x37, 0x38, 0x20 and 0x39. Bits 31:24 of each word hold (code + 16 × channel) mod 256, where channel is `chan_i` sampled with the trigger. Bits 23:0 hold the value.
- R3: The sample presented in the trigger cycle is time 0. The window-start word carries the effective start offset S as a 24-bit two's-complement value.
- R4: The integral word holds the sum, over samples S to S+L−1, of (sample − baseline) as a signed 24-bit two's-complement value. L is the effective length, and the baseline is `base_i` sampled with the trigger.
- R5: The pre-window mean word holds floor((sum of samples S−4 to S−1) / 4), zero-extended.
- R6: The post-window mean word holds floor((sum of samples S+L to S+L+3) / 4), zero-extended.
- R7: A start offset below −(DEPTH−5) (−59 by default) is replaced by −(DEPTH−5). A positive offset is served by waiting for the samples to arrive.
- R8: A window length below 4 is treated as 4.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` does not change. No word is lost or repeated.
- R10: A trigger that arrives while a window is being reduced or its words are being drained is ignored: no extra words appear. `ovr_o` rises in the following cycle and stays high until reset.
- R11: The baseline word holds the latched baseline, zero-extended to 24 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample is taken per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | SAMPLE_W | Current sample (unsigned) |
| base_i | input | SAMPLE_W | Current baseline (unsigned) |
| chan_i | input | 4 | Channel number used in the labels |
| trig_i | input | 1 | Trigger strobe; the sample of this cycle is time 0 |
| offs_i | input | OFFS_W | Signed window start offset in samples |
| len_i | input | LEN_W | Window length in samples |
| out_valid_o | output | 1 | Result word valid |
| out_ready_i | input | 1 | Consumer ready |
| out_data_o | output | 32 | Label byte and 24-bit value |
| ovr_o | output | 1 | Sticky flag for a dropped trigger |

## Verification
A wrong history read pointer or availability test shows up as wrong pre-window, integral or post-window values. It appears in the first result group after the faulty trigger, because all three values come from the same pointer walk. An accumulator phase boundary that is off by one moves a single sample between neighbouring words, so the pre-window mean, integral and post-window mean must be checked separately. A stuck or skipping word index in the output stage shows up in the next group, as a wrong label order or a wrong word count. A busy flag that drops too early shows up as extra words after an overlapping trigger and a missing overrun flag.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

  localparam int WORD_W = 32;
  localparam int VAL_W  = 24;
  localparam int LBL_W  = 8;
  localparam int CHAN_W = 4;
  localparam int NWORDS = 5;
  localparam int FLANK  = 4;

  localparam logic [LBL_W-1:0] LBL_START = 8'h30;
  localparam logic [LBL_W-1:0] LBL_INTEG = 8'h20;
  localparam logic [LBL_W-1:0] LBL_BASE  = 8'h37;
  localparam logic [LBL_W-1:0] LBL_PRE   = 8'h38;
  localparam logic [LBL_W-1:0] LBL_POST  = 8'h39;

  typedef enum logic {CT_IDLE, CT_RUN} pwx_ctl_st_t;

  typedef struct packed {
    logic [VAL_W-1:0] start;
    logic [VAL_W-1:0] base;
    logic [VAL_W-1:0] pre;
    logic [VAL_W-1:0] integ;
    logic [VAL_W-1:0] post;
  } pwx_res_t;

  function automatic logic [WORD_W-1:0] pwx_word(input logic [LBL_W-1:0] code,
                                                 input logic [CHAN_W-1:0] ch,
                                                 input logic [VAL_W-1:0] val);
    logic [LBL_W-1:0] lbl;
    lbl = code + {ch, 4'h0};
    return {lbl, val};
  endfunction

endpackage

// File: rtl/pwx_history.sv
module pwx_history #(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 64,
  parameter int TS_W     = 16,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [SAMPLE_W-1:0] rd_data_o,
  output logic [TS_W-1:0]     wr_idx_o
);

  logic [SAMPLE_W-1:0] ring [DEPTH];
  logic [TS_W-1:0]     wr_idx_q;
  logic [TS_W-1:0]     wr_idx_d;

  // the absolute sample counter advances every cycle
  always_comb begin
    wr_idx_d = wr_idx_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_idx_q <= '0;
    else        wr_idx_q <= wr_idx_d;
  end

  // storage has no reset; entries are only read once written
  always_ff @(posedge clk) begin
    ring[wr_idx_q[AW-1:0]] <= smp_i;
  end

  assign rd_data_o = ring[rd_addr_i];
  assign wr_idx_o  = wr_idx_q;

endmodule

// File: rtl/pwx_window_ctrl.sv
module pwx_window_ctrl
  import pwx_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 64,
  parameter int TS_W     = 16,
  parameter int OFFS_W   = 8,
  parameter int LEN_W    = 10,
  localparam int CNT_W   = LEN_W + 1,
  localparam int PRE_W   = SAMPLE_W + 2,
  localparam int INT_W   = SAMPLE_W + LEN_W + 1,
  localparam int MIN_OFFS = -(DEPTH - 5)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [TS_W-1:0]     trig_idx_i,
  input  logic [OFFS_W-1:0]   offs_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [SAMPLE_W-1:0] base_i,
  input  logic [CHAN_W-1:0]   chan_i,
  input  logic [TS_W-1:0]     wr_idx_i,
  input  logic [SAMPLE_W-1:0] rd_data_i,
  output logic [TS_W-1:0]     rd_idx_o,
  output logic                rd_fire_o,
  output logic                run_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [CHAN_W-1:0]   chan_o,
  output pwx_res_t            res_o
);

  pwx_ctl_st_t                st_q, st_d;
  logic [TS_W-1:0]            rd_q, rd_d;
  logic [CNT_W-1:0]           k_q, k_d;
  logic [LEN_W-1:0]           len_q, len_d;
  logic [SAMPLE_W-1:0]        base_q, base_d;
  logic signed [OFFS_W-1:0]   offs_q, offs_d;
  logic [CHAN_W-1:0]          chan_q, chan_d;
  logic [PRE_W-1:0]           pre_q, pre_d;
  logic [PRE_W-1:0]           post_q, post_d;
  logic signed [INT_W-1:0]    int_q, int_d;
  logic                       done_q, done_d;

  logic signed [OFFS_W-1:0]   eff_offs;
  logic [LEN_W-1:0]           eff_len;
  logic [TS_W-1:0]            start_idx;
  logic [TS_W-1:0]            age;
  logic                       avail;
  logic                       rd_fire;
  logic                       in_pre;
  logic                       in_int;
  logic                       is_last;
  logic signed [SAMPLE_W:0]   dlt;

  // operand conditioning at the trigger
  always_comb begin
    if ($signed(offs_i) < MIN_OFFS) eff_offs = OFFS_W'(MIN_OFFS);
    else                            eff_offs = $signed(offs_i);
    if (len_i < LEN_W'(FLANK)) eff_len = LEN_W'(FLANK);
    else                       eff_len = len_i;
    start_idx = trig_idx_i + TS_W'(eff_offs) - TS_W'(FLANK);
  end

  // a sample is readable once it has been written (age >= 1)
  always_comb begin
    age     = wr_idx_i - rd_q;
    avail   = !age[TS_W-1] && (age != '0);
    rd_fire = (st_q == CT_RUN) && avail;
    in_pre  = k_q < CNT_W'(FLANK);
    in_int  = k_q < (CNT_W'(len_q) + CNT_W'(FLANK));
    is_last = k_q == (CNT_W'(len_q) + CNT_W'(2 * FLANK - 1));
    dlt     = $signed({1'b0, rd_data_i}) - $signed({1'b0, base_q});
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    rd_d   = rd_q;
    k_d    = k_q;
    len_d  = len_q;
    base_d = base_q;
    offs_d = offs_q;
    chan_d = chan_q;
    pre_d  = pre_q;
    post_d = post_q;
    int_d  = int_q;
    done_d = 1'b0;
    if (start_i) begin
      st_d   = CT_RUN;
      rd_d   = start_idx;
      k_d    = '0;
      len_d  = eff_len;
      base_d = base_i;
      offs_d = eff_offs;
      chan_d = chan_i;
      pre_d  = '0;
      post_d = '0;
      int_d  = '0;
    end else if (rd_fire) begin
      rd_d = rd_q + TS_W'(1);
      k_d  = k_q + CNT_W'(1);
      if (in_pre)      pre_d  = pre_q + PRE_W'(rd_data_i);
      else if (in_int) int_d  = int_q + INT_W'(dlt);
      else             post_d = post_q + PRE_W'(rd_data_i);
      if (is_last) begin
        st_d   = CT_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CT_IDLE;
      rd_q   <= '0;
      k_q    <= '0;
      len_q  <= '0;
      base_q <= '0;
      offs_q <= '0;
      chan_q <= '0;
      pre_q  <= '0;
      post_q <= '0;
      int_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rd_q   <= rd_d;
      k_q    <= k_d;
      len_q  <= len_d;
      base_q <= base_d;
      offs_q <= offs_d;
      chan_q <= chan_d;
      pre_q  <= pre_d;
      post_q <= post_d;
      int_q  <= int_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    res_o.start = VAL_W'(offs_q);
    res_o.base  = VAL_W'(base_q);
    res_o.pre   = VAL_W'(pre_q >> 2);
    res_o.integ = VAL_W'(int_q);
    res_o.post  = VAL_W'(post_q >> 2);
  end

  assign rd_idx_o  = rd_q;
  assign rd_fire_o = rd_fire;
  assign run_o     = st_q == CT_RUN;
  assign busy_o    = (st_q == CT_RUN) || done_q;
  assign done_o    = done_q;
  assign chan_o    = chan_q;

endmodule

// File: rtl/pwx_emitter.sv
module pwx_emitter
  import pwx_pkg::*;
#(
  localparam int IW = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  pwx_res_t          res_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              busy_o
);

  logic [WORD_W-1:0] words_q [NWORDS];
  logic [WORD_W-1:0] words_d [NWORDS];
  logic [IW-1:0]     idx_q, idx_d;
  logic              valid_q, valid_d;
  logic              take;
  logic              at_end;

  always_comb begin
    words_d[0] = pwx_word(LBL_START, chan_i, res_i.start);
    words_d[1] = pwx_word(LBL_BASE,  chan_i, res_i.base);
    words_d[2] = pwx_word(LBL_PRE,   chan_i, res_i.pre);
    words_d[3] = pwx_word(LBL_INTEG, chan_i, res_i.integ);
    words_d[4] = pwx_word(LBL_POST,  chan_i, res_i.post);
  end

  always_comb begin
    take    = valid_q && out_ready_i;
    at_end  = idx_q == IW'(NWORDS - 1);
    idx_d   = idx_q;
    valid_d = valid_q;
    if (load_i) begin
      idx_d   = '0;
      valid_d = 1'b1;
    end else if (take) begin
      if (at_end) valid_d = 1'b0;
      else        idx_d   = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      words_q[g] <= '0;
      else if (load_i) words_q[g] <= words_d[g];
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = words_q[idx_q];
  assign busy_o      = valid_q;

endmodule

// File: rtl/pulse_window_extractor.sv
module pulse_window_extractor
  import pwx_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 64,
  parameter int TS_W     = 16,
  parameter int OFFS_W   = 8,
  parameter int LEN_W    = 10,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [SAMPLE_W-1:0] base_i,
  input  logic [CHAN_W-1:0]   chan_i,
  input  logic                trig_i,
  input  logic [OFFS_W-1:0]   offs_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [WORD_W-1:0]   out_data_o,
  output logic                ovr_o
);

  logic [TS_W-1:0]     wr_idx;
  logic [TS_W-1:0]     rd_idx;
  logic [SAMPLE_W-1:0] rd_data;
  logic                rd_fire;
  logic                ctl_run;
  logic                ctl_busy;
  logic                ctl_done;
  logic                em_busy;
  logic                busy;
  logic                accept;
  logic [CHAN_W-1:0]   chan_q;
  pwx_res_t            res;
  logic                ovr_q, ovr_d;

  always_comb begin
    busy   = ctl_busy || em_busy;
    accept = trig_i && !busy;
    ovr_d  = ovr_q || (trig_i && busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  pwx_history #(
    .SAMPLE_W (SAMPLE_W),
    .DEPTH    (DEPTH),
    .TS_W     (TS_W)
  ) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_i     (smp_i),
    .rd_addr_i (rd_idx[AW-1:0]),
    .rd_data_o (rd_data),
    .wr_idx_o  (wr_idx)
  );

  pwx_window_ctrl #(
    .SAMPLE_W (SAMPLE_W),
    .DEPTH    (DEPTH),
    .TS_W     (TS_W),
    .OFFS_W   (OFFS_W),
    .LEN_W    (LEN_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (accept),
    .trig_idx_i (wr_idx),
    .offs_i     (offs_i),
    .len_i      (len_i),
    .base_i     (base_i),
    .chan_i     (chan_i),
    .wr_idx_i   (wr_idx),
    .rd_data_i  (rd_data),
    .rd_idx_o   (rd_idx),
    .rd_fire_o  (rd_fire),
    .run_o      (ctl_run),
    .busy_o     (ctl_busy),
    .done_o     (ctl_done),
    .chan_o     (chan_q),
    .res_o      (res)
  );

  pwx_emitter u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (ctl_done),
    .res_i       (res),
    .chan_i      (chan_q),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .busy_o      (em_busy)
  );

  assign ovr_o = ovr_q;

endmodule

// File: rtl/pwx_checker.sv
module pwx_checker #(
  parameter int TS_W  = 16,
  parameter int DEPTH = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trig_i,
  input logic            busy,
  input logic            ctl_run,
  input logic            rd_fire,
  input logic [TS_W-1:0] wr_idx,
  input logic [TS_W-1:0] rd_idx,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [31:0]     out_data_o,
  input logic            ovr_o
);

  logic [TS_W-1:0] age;
  assign age = wr_idx - rd_idx;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |=> ovr_o); // R10

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> $past(trig_i && busy)); // R10

  AST_NO_WORDS_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_run |-> !out_valid_o); // R2

  AST_READ_NOT_OVERWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> (age <= TS_W'(DEPTH))); // R7

endmodule

bind pulse_window_extractor pwx_checker #(
  .TS_W  (TS_W),
  .DEPTH (DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_i      (trig_i),
  .busy        (busy),
  .ctl_run     (ctl_run),
  .rd_fire     (rd_fire),
  .wr_idx      (wr_idx),
  .rd_idx      (rd_idx),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .ovr_o       (ovr_o)
);

// File: tb/pulse_window_extractor_tb.sv
module pulse_window_extractor_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] smp;
  logic [11:0] base;
  logic [3:0]  chan;
  logic        trig;
  logic [7:0]  offs;
  logic [9:0]  len;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        ovr;

  int checks = 0;
  int errors = 0;
  int cur_idx = 0;
  logic [31:0] got [5];
  logic [31:0] exp_w [5];

  always #10 clk = ~clk;

  pulse_window_extractor u_dut (
    .clk (clk), .rst_n (rst_n), .smp_i (smp), .base_i (base), .chan_i (chan),
    .trig_i (trig), .offs_i (offs), .len_i (len), .out_valid_o (out_valid),
    .out_ready_i (out_ready), .out_data_o (out_data), .ovr_o (ovr)
  );

  function automatic int samp(input int n);
    return 1800 + ((n * 97 + (n / 7) * 13) % 400);
  endfunction

  function automatic logic [31:0] mkw(input int code, input int ch, input int val);
    logic [7:0]  l;
    logic [23:0] v;
    l = 8'(code + 16 * ch);
    v = 24'(val);
    return {l, v};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // sample source: index n is written by the DUT at the n-th edge after reset
  initial begin
    smp = 12'(samp(0));
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      cur_idx++;
      smp = 12'(samp(cur_idx));
    end
  end

  task automatic compute(input int t, input int off, input int ln, input int b,
                         input int ch);
    int s, l, pre, integ, post;
    s = (off < -59) ? -59 : off;
    l = (ln < 4) ? 4 : ln;
    pre = 0; integ = 0; post = 0;
    for (int i = 0; i < 4; i++) pre += samp(t + s - 4 + i);
    for (int i = 0; i < l; i++) integ += samp(t + s + i) - b;
    for (int i = 0; i < 4; i++) post += samp(t + s + l + i);
    exp_w[0] = mkw(8'h30, ch, s);
    exp_w[1] = mkw(8'h37, ch, b);
    exp_w[2] = mkw(8'h38, ch, pre / 4);
    exp_w[3] = mkw(8'h20, ch, integ);
    exp_w[4] = mkw(8'h39, ch, post / 4);
  endtask

  task automatic fire(input int off, input int ln, input int b, input int ch,
                      output int t);
    @(negedge clk); #1;
    trig = 1'b1; offs = 8'(off); len = 10'(ln); base = 12'(b); chan = 4'(ch);
    t = cur_idx;
    @(negedge clk); #1;
    trig = 1'b0; base = 12'h5A5; chan = 4'hF; offs = 8'h7F; len = 10'd3;
  endtask

  task automatic collect(input bit stall, input string tag);
    int n = 0;
    int cyc = 0;
    bit have_prev = 0;
    logic [31:0] prev = '0;
    while (n < 5 && cyc < 1000) begin
      @(negedge clk); #1;
      out_ready = stall ? (cyc % 3 == 2) : 1'b1;
      #1;
      if (have_prev)
        check(out_valid && out_data == prev, "R9 stall hold", out_data, prev);
      have_prev = out_valid && !out_ready;
      prev = out_data;
      if (out_valid && out_ready) begin
        got[n] = out_data;
        n++;
      end
      cyc++;
    end
    @(negedge clk); #1;
    out_ready = 1'b0;
    check(n == 5, {tag, " R2 word count"}, 32'(n), 32'd5);
    check(got[0] == exp_w[0], {tag, " R2 R3 start word"}, got[0], exp_w[0]);
    check(got[1] == exp_w[1], {tag, " R2 R11 baseline word"}, got[1], exp_w[1]);
    check(got[2] == exp_w[2], {tag, " R2 R5 pre mean word"}, got[2], exp_w[2]);
    check(got[3] == exp_w[3], {tag, " R2 R4 integral word"}, got[3], exp_w[3]);
    check(got[4] == exp_w[4], {tag, " R2 R6 post mean word"}, got[4], exp_w[4]);
  endtask

  task automatic expect_quiet(input string tag);
    out_ready = 1'b1;
    repeat (8) begin
      @(negedge clk); #2;
      check(!out_valid, {tag, " R10 no extra words"}, 32'(out_valid), 32'd0);
    end
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    #2;
    check(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 32'd0);
    check(ovr == 1'b0, "R1 overrun after reset", 32'(ovr), 32'd0);
  endtask

  task automatic t_basic();
    int t;
    fire(3, 8, 1900, 0, t);
    compute(t, 3, 8, 1900, 0);
    collect(0, "basic");
  endtask

  task automatic t_before_trigger();
    int t;
    fire(-20, 16, 2100, 5, t);
    compute(t, -20, 16, 2100, 5);
    collect(0, "negative offset");
  endtask

  task automatic t_clamp();
    int t;
    fire(-100, 6, 1750, 2, t);
    compute(t, -100, 6, 1750, 2);
    collect(0, "R7 clamp");
    fire(-59, 5, 2000, 1, t);
    compute(t, -59, 5, 2000, 1);
    collect(0, "R7 min edge");
  endtask

  task automatic t_short_len();
    int t;
    fire(0, 2, 1990, 3, t);
    compute(t, 0, 2, 1990, 3);
    collect(0, "R8 short");
    fire(1, 0, 1990, 4, t);
    compute(t, 1, 0, 1990, 4);
    collect(0, "R8 zero");
  endtask

  task automatic t_stall();
    int t;
    fire(10, 30, 1950, 14, t);
    compute(t, 10, 30, 1950, 14);
    collect(1, "R9 stall");
  endtask

  task automatic t_overrun();
    int t, t2;
    fire(5, 40, 2010, 6, t);
    compute(t, 5, 40, 2010, 6);
    repeat (3) @(negedge clk);
    fire(0, 4, 1000, 9, t2);
    @(negedge clk); #2;
    check(ovr == 1'b1, "R10 overrun set", 32'(ovr), 32'd1);
    collect(0, "R10 first kept");
    expect_quiet("overrun");
    fire(-8, 12, 1880, 7, t);
    compute(t, -8, 12, 1880, 7);
    collect(0, "R10 after overrun");
    check(ovr == 1'b1, "R10 overrun sticky", 32'(ovr), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; trig = 1'b0; out_ready = 1'b0;
    base = '0; chan = '0; offs = '0; len = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    t_reset();
    t_basic();
    t_before_trigger();
    t_clamp();
    t_short_len();
    t_stall();
    t_overrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule